// File: doc/BRIEF.md
# SD Card SPI-Mode Bring-Up Sequencer

This block takes a freshly powered SD or MMC card into SPI data mode and works out what kind of card it is. A one-cycle `start` launches the sequence. It first asks a byte shifter for a run of idle bytes with card select held inactive and the slow serial clock selected. It then walks the card through reset, a voltage and version probe, an operating-condition polling loop and, on the newest cards, a capacity read. It finishes by fixing the block length at 512 bytes.

Commands go out as requests to a separate command engine, which handles framing on the wire. Each request carries the command index, a 32-bit argument, the check byte and the number of bytes expected after the status byte. The engine answers with a single-cycle acknowledge carrying the status byte and up to four trailing bytes. The sequencer branches on the exact status values and reports success or failure, a card-type code, and whether block numbers must be scaled by 512 into byte addresses. On success it switches to the fast transfer clock.

Top module: `sd_spi_init`

## Requirements
- R1: After `start`, exactly WAKE_BYTES (default 16) idle-byte requests are made on `wake_req`/`wake_ack`, with `cs_high`=1 and `fast_clk`=0, before any command request.
- R2: The first command is index 0 with argument 0 and check byte 0x95. The sequence goes on only if its status is exactly 0x01, and fails otherwise. Every command uses check byte 0x95 and 0 trailing bytes unless R3 or R4 says otherwise.
- R3: The second command is index 8 with argument 0x000001AA, check byte 0x87 and 4 trailing bytes. Status 0x01 selects the v2 path, 0x05 selects the v1 path, and anything else fails.
- R4: On the v2 path, index 55 (argument 0, status ignored) followed by index 41 with argument 0x40000000 repeats until index 41 returns 0x00. Then index 58 with argument 0 and 4 trailing bytes is issued.
- R5: The first trailing byte of index 58 arrives in `cmd_resp[31:24]`. If its bit 6 is set, the result is type 4 (v2 block-addressed) with `byte_addr`=0. Otherwise it is type 3 (v2) with `byte_addr`=1. A nonzero status from index 58 fails.
- R6: On the v1 path, index 55 then index 41 with argument 0 is issued. If the first index-41 status is ≤1, the card is type 2 (SD v1) and the pair repeats until the status is 0. If it is >1, the card is type 1 (MMC) and index 1 with argument 0 repeats until the status is 0. Both types set `byte_addr`=1.
- R7: After typing, index 16 with argument 512 is issued. A nonzero status fails.
- R8: Success ends with `done`=1, `fail`=0 and `fast_clk`=1. `fast_clk` stays 0 the whole time `busy` is high.
- R9: Each polling loop makes at most MAX_TRY (default 5000) attempts of its polled command. If they run out, the sequence fails.
- R10: Failure ends with `done`=1, `fail`=1, `card_type`=0, `byte_addr`=0 and `fast_clk`=0.
- R11: Results hold until the next `start`, and a `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the sequence (pulse) |
| wake_req | output | 1 | Request one idle 0xFF byte |
| wake_ack | input | 1 | Idle byte sent |
| cs_high | output | 1 | Hold card select inactive during wake-up bytes |
| fast_clk | output | 1 | 1 selects transfer-rate serial clock |
| cmd_req | output | 1 | Command request, held until acknowledged |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_crc | output | 8 | Check byte |
| cmd_tail | output | 3 | Trailing bytes expected after status |
| cmd_ack | input | 1 | Command complete (one cycle) |
| cmd_r1 | input | 8 | Status byte (valid with ack) |
| cmd_resp | input | 32 | Trailing bytes, first in [31:24] |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence finished |
| fail | output | 1 | Sequence failed |
| card_type | output | 3 | 0 none/fail, 1 MMC, 2 SD v1, 3 SD v2, 4 SD v2 block |
| byte_addr | output | 1 | Block numbers must be scaled by 512 |

## Verification
The hardest condition to reach is retry exhaustion. The card must stay busy for exactly the full attempt budget, so the polled command has to go out thousands of times and the loop must stop on the last permitted attempt, not one before or after it. The bench's card model answers busy for an unlimited number of attempts. Its reference queue expects exactly MAX_TRY command pairs before the failure report, so any extra or missing attempt shows up as a command mismatch. The two v1 branches are also reached only through the exact value of the first operating-condition status, so the model sets that first answer separately from the later ones.

// File: rtl/sd_spi_init.sv
module sd_spi_init #(
  parameter int WAKE_BYTES = 16,
  parameter int MAX_TRY    = 5000,
  parameter int BLK_LEN    = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        wake_req,
  input  logic        wake_ack,
  output logic        cs_high,
  output logic        fast_clk,
  output logic        cmd_req,
  output logic [5:0]  cmd_index,
  output logic [31:0] cmd_arg,
  output logic [7:0]  cmd_crc,
  output logic [2:0]  cmd_tail,
  input  logic        cmd_ack,
  input  logic [7:0]  cmd_r1,
  input  logic [31:0] cmd_resp,
  output logic        busy,
  output logic        done,
  output logic        fail,
  output logic [2:0]  card_type,
  output logic        byte_addr
);
  localparam int WW = $clog2(WAKE_BYTES + 1);
  localparam int TW = $clog2(MAX_TRY + 1);
  localparam logic [2:0] T_NONE = 3'd0, T_MMC = 3'd1, T_SD1 = 3'd2, T_SD2 = 3'd3, T_SD2B = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_WAKE, S_RST, S_IFC, S_V2APP, S_V2OP, S_OCR,
    S_V1APP, S_V1OP, S_MMC, S_BLEN
  } st_t;

  st_t st;
  logic [WW-1:0] wake_cnt;
  logic [TW-1:0] tries;
  logic          last_try;

  assign busy     = (st != S_IDLE);
  assign wake_req = (st == S_WAKE);
  assign cs_high  = (st == S_WAKE);
  assign cmd_req  = busy && (st != S_WAKE);
  assign last_try = (tries == TW'(MAX_TRY - 1));

  always_comb begin
    cmd_index = 6'd0;
    cmd_arg   = 32'd0;
    cmd_crc   = 8'h95;
    cmd_tail  = 3'd0;
    case (st)
      S_IFC:            begin cmd_index = 6'd8;  cmd_arg = 32'h0000_01AA; cmd_crc = 8'h87; cmd_tail = 3'd4; end
      S_V2APP, S_V1APP: cmd_index = 6'd55;
      S_V2OP:           begin cmd_index = 6'd41; cmd_arg = 32'h4000_0000; end
      S_V1OP:           cmd_index = 6'd41;
      S_OCR:            begin cmd_index = 6'd58; cmd_tail = 3'd4; end
      S_MMC:            cmd_index = 6'd1;
      S_BLEN:           begin cmd_index = 6'd16; cmd_arg = 32'(BLK_LEN); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; wake_cnt <= '0; tries <= '0;
      done <= 1'b0; fail <= 1'b0; card_type <= T_NONE; byte_addr <= 1'b0; fast_clk <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_WAKE; wake_cnt <= '0; tries <= '0;
          done <= 1'b0; fail <= 1'b0; card_type <= T_NONE; byte_addr <= 1'b0; fast_clk <= 1'b0;
        end
        S_WAKE: if (wake_ack) begin
          if (wake_cnt == WW'(WAKE_BYTES - 1)) st <= S_RST;
          else wake_cnt <= wake_cnt + 1'b1;
        end
        default: if (cmd_ack) begin
          case (st)
            S_RST: if (cmd_r1 == 8'h01) st <= S_IFC;
                   else begin st <= S_IDLE; done <= 1'b1; fail <= 1'b1; end
            S_IFC: begin
              tries <= '0;
              if (cmd_r1 == 8'h01)      st <= S_V2APP;
              else if (cmd_r1 == 8'h05) st <= S_V1APP;
              else begin st <= S_IDLE; done <= 1'b1; fail <= 1'b1; end
            end
            S_V2APP: st <= S_V2OP;
            S_V2OP:
              if (cmd_r1 == 8'h00) st <= S_OCR;
              else if (last_try) begin st <= S_IDLE; done <= 1'b1; fail <= 1'b1; end
              else begin tries <= tries + 1'b1; st <= S_V2APP; end
            S_OCR:
              if (cmd_r1 != 8'h00) begin st <= S_IDLE; done <= 1'b1; fail <= 1'b1; end
              else begin
                st        <= S_BLEN;
                card_type <= cmd_resp[30] ? T_SD2B : T_SD2;
                byte_addr <= ~cmd_resp[30];
              end
            S_V1APP: st <= S_V1OP;
            S_V1OP:
              if (tries == '0 && cmd_r1 > 8'h01) begin
                card_type <= T_MMC; byte_addr <= 1'b1; st <= S_MMC;
              end else begin
                if (tries == '0) begin card_type <= T_SD1; byte_addr <= 1'b1; end
                if (cmd_r1 == 8'h00) st <= S_BLEN;
                else if (last_try) begin
                  st <= S_IDLE; done <= 1'b1; fail <= 1'b1; card_type <= T_NONE; byte_addr <= 1'b0;
                end else begin tries <= tries + 1'b1; st <= S_V1APP; end
              end
            S_MMC:
              if (cmd_r1 == 8'h00) st <= S_BLEN;
              else if (last_try) begin
                st <= S_IDLE; done <= 1'b1; fail <= 1'b1; card_type <= T_NONE; byte_addr <= 1'b0;
              end else tries <= tries + 1'b1;
            S_BLEN:
              if (cmd_r1 == 8'h00) begin st <= S_IDLE; done <= 1'b1; fast_clk <= 1'b1; end
              else begin
                st <= S_IDLE; done <= 1'b1; fail <= 1'b1; card_type <= T_NONE; byte_addr <= 1'b0;
              end
            default: st <= S_IDLE;
          endcase
        end
      endcase
    end
  end

  // R8
  slow_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fast_clk);

  // R1
  wake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_req && cmd_req));

  // R10
  fail_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (done && card_type == 3'd0 && !byte_addr && !fast_clk));

  // R11
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(card_type) && $stable(done) && $stable(fail) && $stable(byte_addr)));

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !cmd_ack && !wake_ack) |=> busy);

  // R5
  type_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> (byte_addr == (card_type != 3'd4)));

  // R2
  cmd_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_index != 6'd8) |-> (cmd_crc == 8'h95));
endmodule

// File: tb/sim_sd_spi_init.sv
module sim_sd_spi_init;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic wake_ack = 1'b0, cmd_ack = 1'b0;
  logic [7:0] cmd_r1 = 8'hFF;
  logic [31:0] cmd_resp = 32'h0;
  logic wake_req, cs_high, fast_clk, cmd_req, busy, done, fail, byte_addr;
  logic [5:0] cmd_index;
  logic [31:0] cmd_arg;
  logic [7:0] cmd_crc;
  logic [2:0] cmd_tail, card_type;

  sd_spi_init u0 (.clk, .rst_n, .start, .wake_req, .wake_ack, .cs_high, .fast_clk,
    .cmd_req, .cmd_index, .cmd_arg, .cmd_crc, .cmd_tail, .cmd_ack, .cmd_r1, .cmd_resp,
    .busy, .done, .fail, .card_type, .byte_addr);

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  int wake_seen = 0;
  bit first_cmd = 0;
  int exp_idx[$];
  int exp_arg[$];

  // card model scenario
  int r0, r8, r58, r16, first41, busy41, busy1, n41, n1;
  logic [31:0] ocr;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic expect_cmd(input int idx, input int arg);
    exp_idx.push_back(idx); exp_arg.push_back(arg);
  endtask

  function automatic int answer(input int idx);
    case (idx)
      0: return r0;
      8: return r8;
      55: return 1;
      41: begin n41++; if (n41 == 1 && first41 > 1) return first41;
                 if (n41 <= busy41) return (n41 == 1) ? first41 : 1; return 0; end
      1: begin n1++; return (n1 <= busy1) ? 1 : 0; end
      58: return r58;
      16: return r16;
      default: return 8'hFF;
    endcase
  endfunction

  initial begin
    forever begin
      cyc++;
      if (cyc > 190000) begin
        fails++; $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
      @(posedge clk);
    end
  end

  // per-clock comparison of invariants
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && busy) chk(!fast_clk, "R8 slow clock while busy", fast_clk, 0);
      if (rst_n && cmd_req) chk(!cs_high, "R1 cs inactive only in wake", cs_high, 0);
    end
  end

  // card / engine model
  initial begin
    forever begin
      @(negedge clk);
      if (wake_req) begin
        chk(cs_high && !fast_clk, "R1 wake levels", {cs_high, fast_clk}, 2);
        wake_seen++;
        wake_ack = 1'b1;
        @(negedge clk);
        wake_ack = 1'b0;
      end else if (cmd_req) begin
        int idx, ea, ecrc, etail;
        idx = int'(cmd_index);
        if (first_cmd) begin
          first_cmd = 0;
          chk(wake_seen == 16, "R1 wake byte count", wake_seen, 16);
        end
        if (exp_idx.size() == 0) chk(0, "R2 unexpected command", idx, 99);
        else begin
          int ei;
          ei = exp_idx.pop_front(); ea = exp_arg.pop_front();
          chk(idx == ei && cmd_arg == 32'(ea),
              (ei == 41 || ei == 1) ? "R9 poll command" : (ei == 16 ? "R7 block length cmd" : "R4 command order"),
              {idx, cmd_arg}, {ei, 32'(ea)});
        end
        ecrc  = (idx == 8) ? 8'h87 : 8'h95;
        etail = (idx == 8 || idx == 58) ? 4 : 0;
        chk(cmd_crc == 8'(ecrc) && cmd_tail == 3'(etail), "R3 check byte and tail",
            {cmd_crc, cmd_tail}, {8'(ecrc), 3'(etail)});
        cmd_r1 = 8'(answer(idx));
        cmd_resp = (idx == 58) ? ocr : 32'h0000_01AA;
        @(negedge clk);
        @(negedge clk);
        cmd_ack = 1'b1;
        @(negedge clk);
        cmd_ack = 1'b0;
        cmd_r1 = 8'hFF;
      end
    end
  end

  task automatic setup(input int a0, input int a8, input int f41, input int b41, input int b1,
                       input logic [31:0] o, input int a58, input int a16);
    r0 = a0; r8 = a8; first41 = f41; busy41 = b41; busy1 = b1; ocr = o; r58 = a58; r16 = a16;
    n41 = 0; n1 = 0; exp_idx.delete(); exp_arg.delete(); wake_seen = 0; first_cmd = 1;
  endtask

  task automatic run(input string req, input bit efail, input int etype, input bit eba, input bit poke);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(done && fail == efail, {req, " done/fail"}, {done, fail}, {1'b1, efail});
    chk(card_type == 3'(etype), {req, " card type"}, card_type, etype);
    chk(byte_addr == eba, {req, " address scaling"}, byte_addr, eba);
    chk(fast_clk == !efail, efail ? "R10 clock stays slow" : "R8 fast clock", fast_clk, !efail);
    chk(exp_idx.size() == 0, {req, " all commands seen"}, exp_idx.size(), 0);
    repeat (10) @(negedge clk);
    chk(done && fail == efail && card_type == 3'(etype) && byte_addr == eba, "R11 result held",
        card_type, etype);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && card_type == 0 && !fast_clk && !cmd_req && !wake_req,
        "R10 reset state", {busy, done, fail, card_type}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // v2 block-addressed, 3 busy polls
    setup(1, 1, 1, 3, 0, 32'hC0FF_8000, 0, 0);
    expect_cmd(0, 0); expect_cmd(8, 'h1AA);
    for (int i = 0; i < 4; i++) begin expect_cmd(55, 0); expect_cmd(41, 'h4000_0000); end
    expect_cmd(58, 0); expect_cmd(16, 512);
    run("R5 v2 block", 0, 4, 0, 0);

    // v2 standard, start pulse while busy ignored
    setup(1, 1, 0, 0, 0, 32'h80FF_8000, 0, 0);
    expect_cmd(0, 0); expect_cmd(8, 'h1AA); expect_cmd(55, 0); expect_cmd(41, 'h4000_0000);
    expect_cmd(58, 0); expect_cmd(16, 512);
    run("R11 R5 v2 std", 0, 3, 1, 1);

    // SD v1 with 2 busy polls
    setup(1, 5, 1, 2, 0, 0, 0, 0);
    expect_cmd(0, 0); expect_cmd(8, 'h1AA);
    for (int i = 0; i < 3; i++) begin expect_cmd(55, 0); expect_cmd(41, 0); end
    expect_cmd(16, 512);
    run("R6 sd v1", 0, 2, 1, 0);

    // SD v1 ready on first attempt
    setup(1, 5, 0, 0, 0, 0, 0, 0);
    expect_cmd(0, 0); expect_cmd(8, 'h1AA); expect_cmd(55, 0); expect_cmd(41, 0); expect_cmd(16, 512);
    run("R6 sd v1 immediate", 0, 2, 1, 0);

    // MMC
    setup(1, 5, 5, 1, 2, 0, 0, 0);
    expect_cmd(0, 0); expect_cmd(8, 'h1AA); expect_cmd(55, 0); expect_cmd(41, 0);
    for (int i = 0; i < 3; i++) expect_cmd(1, 0);
    expect_cmd(16, 512);
    run("R6 mmc", 0, 1, 1, 0);

    // reset status wrong
    setup(0, 1, 0, 0, 0, 0, 0, 0);
    expect_cmd(0, 0);
    run("R2 bad reset status", 1, 0, 0, 0);

    // version probe wrong
    setup(1, 9, 0, 0, 0, 0, 0, 0);
    expect_cmd(0, 0); expect_cmd(8, 'h1AA);
    run("R3 bad probe status", 1, 0, 0, 0);

    // capacity read error
    setup(1, 1, 0, 0, 0, 32'hC0FF_8000, 4, 0);
    expect_cmd(0, 0); expect_cmd(8, 'h1AA); expect_cmd(55, 0); expect_cmd(41, 'h4000_0000); expect_cmd(58, 0);
    run("R5 capacity read error", 1, 0, 0, 0);

    // block length error
    setup(1, 5, 1, 1, 0, 0, 0, 4);
    expect_cmd(0, 0); expect_cmd(8, 'h1AA);
    for (int i = 0; i < 2; i++) begin expect_cmd(55, 0); expect_cmd(41, 0); end
    expect_cmd(16, 512);
    run("R7 block length error", 1, 0, 0, 0);

    // v2 never ready: retry limit
    setup(1, 1, 1, 1000000, 0, 0, 0, 0);
    expect_cmd(0, 0); expect_cmd(8, 'h1AA);
    for (int i = 0; i < 5000; i++) begin expect_cmd(55, 0); expect_cmd(41, 'h4000_0000); end
    run("R9 retry exhausted", 1, 0, 0, 0);

    // success after a failure
    setup(1, 1, 0, 0, 0, 32'hC000_0000, 0, 0);
    expect_cmd(0, 0); expect_cmd(8, 'h1AA); expect_cmd(55, 0); expect_cmd(41, 'h4000_0000);
    expect_cmd(58, 0); expect_cmd(16, 512);
    run("R4 restart v2", 0, 4, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule